// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter, 4 bits wide by default, with a parallel preset and two separate count enables. Every change of the count except an asynchronous clear happens on the rising clock edge. One enable is the parallel enable. The other is the trickle enable, and it also gates the terminal-count flag. Because of this, several stages can be chained into one wider synchronous counter: the flag of each stage drives the trickle enable of the next stage. All stages share the clock and the parallel enable.

The clear input is active low. The build-time parameter `ASYNC_CLEAR` chooses how it acts. With `ASYNC_CLEAR = 1` the clear zeroes the count at once, without a clock edge. With `ASYNC_CLEAR = 0` the count goes to zero on the next rising edge. The modes have a fixed precedence, highest first: clear, parallel load, count, hold. All pins are plain control and data pins. There is no streaming data path, so there is no handshake.

Top module: `cascade_counter`

## Requirements
- R1: While counting, the count advances in binary modulo 2^WIDTH. From the all-ones value (15 for WIDTH=4) it goes to 0.
- R2: On a rising edge the highest-ranked active mode wins. The order is clear (clr_n=0), then load (load_n=0), then count, then hold.
- R3: With ASYNC_CLEAR=1, clr_n=0 forces the count to 0 at once, before any clock edge. The count stays 0 while clr_n is low, whatever the other inputs are.
- R4: With ASYNC_CLEAR=0, clr_n=0 leaves the count unchanged until the next rising edge. That edge sets the count to 0, and load and count have no effect.
- R5: With clr_n=1 and load_n=0, a rising edge copies din into the count, whatever the values of en_par and en_trk.
- R6: With clr_n=1, load_n=1, en_par=1 and en_trk=1, a rising edge increments the count by one.
- R7: With clr_n=1 and load_n=1, a rising edge leaves the count unchanged when en_par=0 or en_trk=0.
- R8: term_cnt is 1 exactly when en_trk=1 and the count is all ones. It follows these inputs combinationally in the same cycle, and en_par and load_n have no effect on it.
- R9: Three 4-bit stages chained as follows form a correct 12-bit synchronous counter that wraps from 4095 to 0. Each stage's term_cnt feeds the next stage's en_trk. All stages share en_par and the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLEAR |
| load_n | input | 1 | Active-low parallel-load enable |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates term_cnt |
| din | input | WIDTH | Preset value loaded when load_n is low |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | Terminal-count flag, high when en_trk is high and count is all ones |

## Verification
The clocked properties assume that clr_n, load_n, en_par, en_trk and din are stable around each rising edge. They also assume that a release of clr_n never lands on an edge. The bench meets both assumptions by changing every input on the falling clock edge only. For the asynchronous variant, the bench samples the count one time unit after it lowers the clear, while the clock is still low. That sample shows that the zero arrives with no edge. The sample taken at the same moment from the synchronous variant shows that its count is still unchanged.

// File: rtl/cc_pkg.sv
package cc_pkg;

  // Operating mode of one counter stage, resolved by precedence.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cc_mode_t;

endpackage

// File: rtl/cc_mode_decode.sv
module cc_mode_decode
  import cc_pkg::*;
(
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     en_par,
  input  logic     en_trk,
  output cc_mode_t mode
);

  logic count_go;

  // The internal count enable needs both enables and an inactive load.
  assign count_go = en_par & en_trk & load_n;

  always_comb begin
    if (!clr_n)        mode = MODE_CLEAR;
    else if (!load_n)  mode = MODE_LOAD;
    else if (count_go) mode = MODE_COUNT;
    else               mode = MODE_HOLD;
  end

  // R2: a load is never chosen while the clear is active.
  always_comb begin
    if (!clr_n) assert_clear_first_R2: assert (mode != MODE_LOAD);
  end

endmodule

// File: rtl/cc_count_reg.sv
module cc_count_reg
  import cc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  cc_mode_t         mode,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_nxt = '0;
      MODE_LOAD:  q_nxt = din;
      MODE_COUNT: q_nxt = q + ONE;
      default:    q_nxt = q;
    endcase
  end

  generate
    if (ASYNC_CLEAR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= q_nxt;
      end

      // R3: at any edge seen while clear is held, the count is zero.
      assert_async_zero_R3: assert property (@(posedge clk)
        !clr_n |-> (q == '0));
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        q <= q_nxt;
      end

      // R4: a clear sampled on an edge yields zero after that edge.
      assert_sync_zero_R4: assert property (@(posedge clk)
        !clr_n |=> (q == '0));
    end
  endgenerate

endmodule

// File: rtl/cc_term_detect.sv
module cc_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             term
);

  logic at_top;

  assign at_top = &q;
  assign term   = at_top & en_trk;

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);

  cc_mode_t mode;

  cc_mode_decode u_decode (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .mode   (mode)
  );

  cc_count_reg #(
    .WIDTH       (WIDTH),
    .ASYNC_CLEAR (ASYNC_CLEAR)
  ) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .mode  (mode),
    .din   (din),
    .q     (count)
  );

  cc_term_detect #(
    .WIDTH (WIDTH)
  ) u_term (
    .q      (count),
    .en_trk (en_trk),
    .term   (term_cnt)
  );

  // R5: a load takes din whatever the enables are.
  assert_load_takes_din_R5: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (count == $past(din)));

  // R6: both enables high with no load gives an increment.
  assert_step_up_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> (count == WIDTH'($past(count) + 1'b1)));

  // R7: either enable low with no load holds the count.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count));

  // R1: the all-ones value wraps to zero when counting.
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk && (count == '1)) |=> (count == '0));

  // R8: the flag implies the trickle enable and a full count.
  assert_flag_only_at_top_R8: assert property (@(posedge clk) disable iff (!clr_n)
    term_cnt |-> (en_trk && (count == '1)));

  // R8: the flag ignores the parallel enable and the load input.
  assert_flag_not_par_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (en_trk && !en_par && (count == '1)) |-> term_cnt);

endmodule

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int STAGES     = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         clr_n, load_n, en_par, en_trk;
  logic [W-1:0] din;
  logic [W-1:0] count_a, count_s;
  logic         term_a, term_s;

  logic         cas_clr_n, cas_en;
  logic [W-1:0] cq [STAGES];
  logic         ct [STAGES];

  int vectors = 0;
  int fails   = 0;
  int exp_a, exp_s, exp_c;

  // Asynchronous-clear variant.
  cascade_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b1)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .count(count_a), .term_cnt(term_a));

  // Synchronous-clear variant, same stimulus.
  cascade_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) dut_s_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .count(count_s), .term_cnt(term_s));

  // Three chained stages forming a 12-bit counter.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic trk;
    if (k == 0) begin : g_first
      assign trk = cas_en;
    end else begin : g_next
      assign trk = ct[k-1];
    end
    cascade_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) u_stage (
      .clk(clk), .clr_n(cas_clr_n), .load_n(1'b1), .en_par(cas_en),
      .en_trk(trk), .din('0), .count(cq[k]), .term_cnt(ct[k]));
  end

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive on the falling edge, check pre-edge state, then post-edge state.
  task automatic step(input logic c, input logic l, input logic p,
                      input logic t, input logic [W-1:0] d,
                      input logic cc, input logic ce, input string tag);
    clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
    cas_clr_n = cc; cas_en = ce;
    #1;
    if (!c) exp_a = 0;
    check(int'(count_a), exp_a, "R3 async clear acts before edge");
    check(int'(count_s), exp_s, "R4 sync count unchanged before edge");
    check(int'(term_a), int'(t && exp_a == 15), "R8 flag async variant");
    check(int'(term_s), int'(t && exp_s == 15), "R8 flag sync variant");
    @(posedge clk);
    exp_a = !c ? 0 : !l ? int'(d) : (p && t) ? (exp_a + 1) % 16 : exp_a;
    exp_s = !c ? 0 : !l ? int'(d) : (p && t) ? (exp_s + 1) % 16 : exp_s;
    exp_c = !cc ? 0 : ce ? (exp_c + 1) % 4096 : exp_c;
    @(negedge clk);
    check(int'(count_a), exp_a, tag);
    check(int'(count_s), exp_s, tag);
    check(int'({cq[2], cq[1], cq[0]}), exp_c, "R9 cascade value");
    check(int'(ct[2]), int'(ce && exp_c == 4095), "R9 cascade top flag");
  endtask

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0; din = '0;
    cas_clr_n = 1'b0; cas_en = 1'b0;
    exp_a = 0; exp_s = 0; exp_c = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // Reset state, clear beats load and count (R2).
    step(0, 0, 1, 1, 4'h9, 0, 0, "R2 clear over load and count");
    check(int'(count_a), 0, "R3 reset state");
    // Load beats count (R2, R5).
    step(1, 0, 1, 1, 4'hA, 1, 0, "R5 load with enables high");
    step(1, 0, 0, 0, 4'h3, 1, 0, "R5 load with enables low");
    // Count up through a wrap (R6, R1).
    for (int i = 0; i < 20; i++) step(1, 1, 1, 1, 4'h0, 1, 0, "R1 R6 count and wrap");
    // Hold on either enable low (R7).
    step(1, 1, 0, 1, 4'h0, 1, 0, "R7 hold parallel low");
    step(1, 1, 1, 0, 4'h0, 1, 0, "R7 hold trickle low");
    step(1, 1, 0, 0, 4'h0, 1, 0, "R7 hold both low");
    // Flag at 15 independent of parallel enable and load (R8).
    step(1, 0, 1, 1, 4'hF, 1, 0, "R5 load 15");
    step(1, 1, 0, 1, 4'h0, 1, 0, "R8 flag with parallel low");
    step(1, 1, 0, 0, 4'h0, 1, 0, "R8 flag off with trickle low");
    step(1, 0, 0, 1, 4'h2, 1, 0, "R8 flag with load low");
    // Mid-run clear (R3, R4).
    step(1, 0, 1, 1, 4'h7, 1, 0, "R5 load 7");
    step(0, 1, 1, 1, 4'h0, 1, 0, "R4 sync clear on edge");
    // Every control combination from several counts (R2).
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 16; m++) begin
        step(1, 0, 1, 1, 4'(s * 5), 1, 0, "R5 preload");
        step(m[3], m[2], m[1], m[0], 4'hC, 1, 0, "R2 control combination");
      end
    end
    // Random stimulus.
    for (int i = 0; i < 400; i++) begin
      step(($urandom_range(0, 15) != 0), ($urandom_range(0, 5) != 0),
           1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
           4'($urandom_range(0, 15)), 1, 0, "R2 random mode mix");
    end
    // Cascade: pause, then run through the 12-bit wrap (R9).
    for (int i = 0; i < 50; i++) step(1, 1, 1, 1, 4'h0, 1, (i % 3 != 0), "R9 gated cascade");
    for (int i = 0; i < 4120; i++) step(1, 1, 1, 1, 4'h0, 1, 1, "R9 cascade run");
    step(1, 1, 1, 1, 4'h0, 0, 1, "R9 cascade clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule